// File: doc/BRIEF.md
# Dual-Mode Serial Register Access Slave

This block is a byte-wide serial slave that opens a 128-entry register space to an external controller. The space has four parts. A clock region sits at indices 00h–1Fh. It contains a control register, a charger-configuration register and a reserved run. User RAM sits at indices 20h–7Fh. The block holds the control and charger registers itself. Every other index is reached through a simple parallel register port, so the register contents stay outside the block.

A mode input selects one of two serial protocols. In the four-wire protocol, data goes in and out on separate lines, most significant bit first, and the idle clock level is learned at the start of each transfer. In the three-wire protocol, one shared data line is used, least significant bit first. Every transfer is framed by an active-high chip select. It begins with one address byte, which sets the direction and the start index. Any number of data bytes follow, and the index advances after each one inside its region.

All serial inputs are sampled by the system clock `clk`. Each serial clock half-period must last at least six `clk` cycles.

Top module: `serialRegSlave`

## Requirements
- R1: While `csel` is high, the first byte received is the address byte. Its bit 7 selects the direction (1 = write, 0 = read) and bits 6:0 give the start index. Read bursts never produce a write, and a write burst puts data into the addressed index.
- R2: With `modeSpi`=1, bytes move MSB first. The level of `sclk` at the rise of `csel` is taken as the idle level. Input bits are captured on the edge that returns `sclk` to idle, and output bits change on the edge that leaves idle. Both idle levels work.
- R3: With `modeSpi`=0, bytes move LSB first. Input bits are captured on the rising `sclk` edge and output bits change on the falling edge. `sdi` and `sdo` are meant to be joined into one line, with `sdoOe` as its drive enable.
- R4: `sdoOe` stays low during the address byte and whenever `csel` is low. It is high while read data is being shifted out.
- R5: After each data byte the index advances by one. Index 1Fh wraps to 00h and index 7Fh wraps to 20h, for both reads and writes (in 8-bit address terms, 9Fh→80h and FFh→A0h).
- R6: Reads of indices 12h–1Fh return 00h. Writes to indices 12h–1Fh change nothing and produce no `regWr` pulse.
- R7: If `csel` falls before the eighth bit of a data byte, that byte is not written.
- R8: While the write-protect bit is set, every write is ignored. The one exception is a write to index 0Fh with bit 6 = 0: that write clears write-protect and leaves the other control bits unchanged.
- R9: Index 0Fh is the control register. Bit 6 is write-protect (`wpOut`), bit 2 is `oneHzEn`, and bits 1:0 are `alarmIrqEn`. All other bits read 0, and every bit resets to 0.
- R10: Index 11h is the charger register, with reset value 5Ch. Bits 3:2 appear on `trickleDiodes` and bits 1:0 on `trickleRes`. `trickleOn` is high only when bits 7:4 = 1010, bits 3:2 are 01 or 10, and bits 1:0 are nonzero.
- R11: Every other index is reached through the register port. A write gives a one-cycle `regWr` pulse carrying `regAddr` and `regWrData`. A read gives a one-cycle `regRd` pulse, and `regRdData` is captured during that same cycle, before the byte's first output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| modeSpi | input | 1 | 1 = four-wire MSB-first, 0 = three-wire LSB-first |
| csel | input | 1 | Active-high transfer frame |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Drive enable for `sdo` |
| regAddr | output | 7 | Register port index |
| regWr | output | 1 | Register port write pulse |
| regWrData | output | 8 | Register port write data |
| regRd | output | 1 | Register port read pulse |
| regRdData | input | 8 | Register port read data |
| wpOut | output | 1 | Write-protect bit |
| oneHzEn | output | 1 | Control bit 2 |
| alarmIrqEn | output | 2 | Control bits 1:0 |
| trickleOn | output | 1 | Charger enable decode |
| trickleDiodes | output | 2 | Charger diode select |
| trickleRes | output | 2 | Charger resistor select |

## Verification
The embedded assertions check invariants on every cycle:
- the output enable never rises outside a read data phase and falls once the frame closes;
- no register-port write appears while write-protect is set, or for the control, charger or reserved indices;
- read and write pulses never coincide;
- the charger enable never rises with a zero resistor select;
- the bit counter restarts each frame.

Only the bench scenarios can show the bit orders, the idle-level detection for both polarities, the region wraps in long bursts, partial-byte aborts, and the clear-only write that lifts write-protect. The bench checks these by comparing data read back and the state of the register port against arithmetic expectations.

// File: rtl/sregPkg.sv
package sregPkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam logic [ADDR_W-1:0] CLK_FIRST = 7'h00;
  localparam logic [ADDR_W-1:0] CLK_LAST  = 7'h1F;
  localparam logic [ADDR_W-1:0] RAM_FIRST = 7'h20;
  localparam logic [ADDR_W-1:0] RAM_LAST  = 7'h7F;
  localparam logic [ADDR_W-1:0] CTRL_IDX  = 7'h0F;
  localparam logic [ADDR_W-1:0] TRK_IDX   = 7'h11;
  localparam logic [ADDR_W-1:0] RSV_FIRST = 7'h12;
  localparam logic [DATA_W-1:0] TRK_RESET = 8'h5C;

  // strobes from framing control to the datapath
  typedef struct packed {
    logic clear;     // frame closed
    logic latchBit;  // capture one input bit
    logic wrCommit;  // full write data byte received
    logic fetch;     // load read buffer for current index
    logic loadOut;   // first output bit of a read byte
    logic shiftOut;  // next output bit
    logic msbFirst;  // bit order
  } strobe_t;

  function automatic logic [ADDR_W-1:0] advancePtr(input logic [ADDR_W-1:0] p);
    if (p == CLK_LAST)      return CLK_FIRST;
    else if (p == RAM_LAST) return RAM_FIRST;
    else                    return p + 1'b1;
  endfunction

  function automatic logic isReserved(input logic [ADDR_W-1:0] p);
    return (p >= RSV_FIRST) && (p <= CLK_LAST);
  endfunction
endpackage

// File: rtl/sregCtrl.sv
module sregCtrl
  import sregPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSpi,
  input  logic              csel,
  input  logic              sclk,
  input  logic [DATA_W-1:0] inByteNext,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] ptr,
  output logic              readPhase
);
  logic ceQ, ceQ2, sclkQ, sclkQ2, cpol, addrPhase, isRead, fetchQ;
  logic [CNT_W-1:0] bitCnt;
  logic ceRise, latchLvl, sclkChg, latchEdge, shiftEdge, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ <= 1'b0; ceQ2 <= 1'b0; sclkQ <= 1'b0; sclkQ2 <= 1'b0;
    end else begin
      ceQ <= csel; ceQ2 <= ceQ; sclkQ <= sclk; sclkQ2 <= sclkQ;
    end
  end

  always_comb begin
    ceRise    = ceQ & ~ceQ2;
    latchLvl  = modeSpi ? cpol : 1'b1;
    sclkChg   = sclkQ ^ sclkQ2;
    latchEdge = ceQ & ~ceRise & sclkChg & (sclkQ == latchLvl);
    shiftEdge = ceQ & ~ceRise & sclkChg & (sclkQ != latchLvl);
    lastBit   = latchEdge & (bitCnt == CNT_W'(DATA_W - 1));
    readPhase = ~addrPhase & isRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpol <= 1'b0; bitCnt <= '0; addrPhase <= 1'b1; isRead <= 1'b0;
      ptr <= '0; fetchQ <= 1'b0;
    end else begin
      fetchQ <= 1'b0;
      if (ceRise) cpol <= sclkQ;
      if (!ceQ) begin
        bitCnt <= '0; addrPhase <= 1'b1; isRead <= 1'b0;
      end else if (latchEdge) begin
        bitCnt <= bitCnt + 1'b1;
        if (lastBit) begin
          if (addrPhase) begin
            addrPhase <= 1'b0;
            isRead    <= ~inByteNext[DATA_W-1];
            ptr       <= inByteNext[ADDR_W-1:0];
            fetchQ    <= ~inByteNext[DATA_W-1];
          end else begin
            ptr    <= advancePtr(ptr);
            fetchQ <= isRead;
          end
        end
      end
    end
  end

  always_comb begin
    stb.clear    = ~ceQ;
    stb.latchBit = latchEdge;
    stb.wrCommit = lastBit & ~addrPhase & ~isRead;
    stb.fetch    = fetchQ;
    stb.loadOut  = shiftEdge & readPhase & (bitCnt == '0);
    stb.shiftOut = shiftEdge & readPhase & (bitCnt != '0);
    stb.msbFirst = modeSpi;
  end

  assert_frame_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ceQ) |-> (bitCnt == '0 && addrPhase));
  assert_read_no_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    readPhase |-> !stb.wrCommit);
endmodule

// File: rtl/sregData.sv
module sregData
  import sregPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              readPhase,
  input  logic              sdi,
  output logic [DATA_W-1:0] inByteNext,
  output logic              sdo,
  output logic              sdoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRd,
  input  logic [DATA_W-1:0] regRdData,
  output logic              wpOut,
  output logic              oneHzEn,
  output logic [1:0]        alarmIrqEn,
  output logic              trickleOn,
  output logic [1:0]        trickleDiodes,
  output logic [1:0]        trickleRes
);
  logic sdiQ, wpQ, oneHzQ, wrPend;
  logic [1:0] aieQ;
  logic [DATA_W-1:0] shiftIn, outReg, rdBuf, trkQ, ctlByte, wrDataQ, rdMux;
  logic [ADDR_W-1:0] wrAddrQ;
  logic isCtl, isTrk, isRsv, isExt;

  always_comb begin
    inByteNext = stb.msbFirst ? {shiftIn[DATA_W-2:0], sdiQ} : {sdiQ, shiftIn[DATA_W-1:1]};
    isCtl   = (ptr == CTRL_IDX);
    isTrk   = (ptr == TRK_IDX);
    isRsv   = isReserved(ptr);
    isExt   = ~isCtl & ~isTrk & ~isRsv;
    ctlByte = {1'b0, wpQ, 3'b000, oneHzQ, aieQ};
    if (isCtl)      rdMux = ctlByte;
    else if (isTrk) rdMux = trkQ;
    else if (isRsv) rdMux = '0;
    else            rdMux = regRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdiQ <= 1'b0; shiftIn <= '0; outReg <= '0; rdBuf <= '0; sdoOe <= 1'b0;
      wpQ <= 1'b0; oneHzQ <= 1'b0; aieQ <= '0; trkQ <= TRK_RESET;
      wrPend <= 1'b0; wrAddrQ <= '0; wrDataQ <= '0;
    end else begin
      sdiQ   <= sdi;
      wrPend <= 1'b0;
      if (stb.latchBit) shiftIn <= inByteNext;
      if (stb.fetch) rdBuf <= rdMux;
      if (stb.clear) sdoOe <= 1'b0;
      else if (stb.loadOut) begin
        outReg <= rdBuf;
        sdoOe  <= 1'b1;
      end else if (stb.shiftOut) begin
        outReg <= stb.msbFirst ? {outReg[DATA_W-2:0], 1'b0} : {1'b0, outReg[DATA_W-1:1]};
      end
      if (stb.wrCommit) begin
        if (!wpQ) begin
          if (isCtl) begin
            wpQ    <= inByteNext[6];
            oneHzQ <= inByteNext[2];
            aieQ   <= inByteNext[1:0];
          end else if (isTrk) begin
            trkQ <= inByteNext;
          end else if (isExt) begin
            wrPend  <= 1'b1;
            wrAddrQ <= ptr;
            wrDataQ <= inByteNext;
          end
        end else if (isCtl && !inByteNext[6]) begin
          wpQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    sdo           = stb.msbFirst ? outReg[DATA_W-1] : outReg[0];
    regWr         = wrPend;
    regWrData     = wrDataQ;
    regAddr       = wrPend ? wrAddrQ : ptr;
    regRd         = stb.fetch & isExt;
    wpOut         = wpQ;
    oneHzEn       = oneHzQ;
    alarmIrqEn    = aieQ;
    trickleDiodes = trkQ[3:2];
    trickleRes    = trkQ[1:0];
    trickleOn     = (trkQ[7:4] == 4'b1010) && (trkQ[3:2] == 2'b01 || trkQ[3:2] == 2'b10)
                    && (trkQ[1:0] != 2'b00);
  end

  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(wpQ) |-> !regWr);
  assert_rsv_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> !(regAddr == CTRL_IDX || regAddr == TRK_IDX || isReserved(regAddr)));
  assert_oe_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> !sdoOe);
  assert_oe_in_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> readPhase);
  assert_one_access_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regWr));
  assert_trickle_res_R10: assert property (@(posedge clk) disable iff (!rstN)
    trickleOn |-> (trickleRes != 2'b00));
endmodule

// File: rtl/serialRegSlave.sv
module serialRegSlave
  import sregPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSpi,
  input  logic              csel,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRd,
  input  logic [DATA_W-1:0] regRdData,
  output logic              wpOut,
  output logic              oneHzEn,
  output logic [1:0]        alarmIrqEn,
  output logic              trickleOn,
  output logic [1:0]        trickleDiodes,
  output logic [1:0]        trickleRes
);
  strobe_t           stb;
  logic [ADDR_W-1:0] ptr;
  logic              readPhase;
  logic [DATA_W-1:0] inByteNext;

  sregCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSpi(modeSpi), .csel(csel), .sclk(sclk),
    .inByteNext(inByteNext), .stb(stb), .ptr(ptr), .readPhase(readPhase)
  );

  sregData data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ptr(ptr), .readPhase(readPhase), .sdi(sdi),
    .inByteNext(inByteNext), .sdo(sdo), .sdoOe(sdoOe), .regAddr(regAddr),
    .regWr(regWr), .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData),
    .wpOut(wpOut), .oneHzEn(oneHzEn), .alarmIrqEn(alarmIrqEn), .trickleOn(trickleOn),
    .trickleDiodes(trickleDiodes), .trickleRes(trickleRes)
  );
endmodule

// File: tb/serialRegSlave_tb_top.sv
module serialRegSlave_tb_top;
  localparam int H = 6;
  logic clk = 1'b0, rstN = 1'b0;
  logic modeD = 1'b1, ceD = 1'b0, sclkD = 1'b0, mosi = 1'b0;
  logic sdo, sdoOe, regWr, regRd, wpOut, oneHzEn, trickleOn;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [1:0] alarmIrqEn, trickleDiodes, trickleRes;
  logic sdiW;
  int checks = 0, failures = 0, addrOeCnt = 0, dataOeBad = 0;
  logic [7:0] extMem [0:127];
  logic [7:0] expMem [0:127];
  logic [7:0] txBuf [0:127];
  logic [7:0] rxBuf [0:127];
  logic [7:0] ctlExp = 8'h00, trkExp = 8'h5C;

  always #10 clk = ~clk;

  assign sdiW = modeD ? mosi : (sdoOe ? sdo : mosi);

  serialRegSlave dut_i (
    .clk(clk), .rstN(rstN), .modeSpi(modeD), .csel(ceD), .sclk(sclkD), .sdi(sdiW),
    .sdo(sdo), .sdoOe(sdoOe), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRd(regRd), .regRdData(regRdData), .wpOut(wpOut), .oneHzEn(oneHzEn),
    .alarmIrqEn(alarmIrqEn), .trickleOn(trickleOn), .trickleDiodes(trickleDiodes),
    .trickleRes(trickleRes)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) extMem[i] <= pat(i);
    end else if (regWr) extMem[regAddr] <= regWrData;
  end
  assign regRdData = extMem[regAddr];

  function automatic int nextIdx(input int a);
    if (a == 'h1F) return 0;
    if (a == 'h7F) return 'h20;
    return a + 1;
  endfunction

  function automatic logic [7:0] expRd(input int a);
    if (a == 'h0F) return ctlExp;
    if (a == 'h11) return trkExp;
    if (a >= 'h12 && a <= 'h1F) return 8'h00;
    return expMem[a];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shiftByte(input bit spi, input bit pol, input logic [7:0] txb, input int nBits,
                           output logic [7:0] rxb, output int oeHigh);
    rxb = 8'h00;
    oeHigh = 0;
    for (int i = 0; i < nBits; i++) begin
      int idx;
      idx = spi ? 7 - i : i;
      sclkD = spi ? ~pol : 1'b0;
      mosi = txb[idx];
      repeat (H) @(negedge clk);
      rxb[idx] = sdo;
      if (sdoOe) oeHigh++;
      sclkD = spi ? pol : 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic xfer(input bit spi, input bit pol, input logic [7:0] addrB, input int nData,
                      input int lastBits);
    logic [7:0] rx;
    int oeN;
    ceD = 1'b0;
    modeD = spi;
    sclkD = spi ? pol : 1'b0;
    repeat (4) @(negedge clk);
    ceD = 1'b1;
    repeat (4) @(negedge clk);
    shiftByte(spi, pol, addrB, 8, rx, oeN);
    addrOeCnt += oeN;
    for (int k = 0; k < nData; k++) begin
      int bits;
      bits = (k == nData - 1) ? lastBits : 8;
      shiftByte(spi, pol, addrB[7] ? txBuf[k] : 8'h00, bits, rx, oeN);
      rxBuf[k] = rx;
      if (!addrB[7] && oeN != bits) dataOeBad++;
    end
    repeat (2) @(negedge clk);
    ceD = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readCheck(input bit spi, input bit pol, input int start, input int n,
                           input string req);
    int a;
    xfer(spi, pol, 8'(start), n, 8);
    a = start;
    for (int k = 0; k < n; k++) begin
      chk(rxBuf[k] == expRd(a), req, rxBuf[k], expRd(a));
      a = nextIdx(a);
    end
  endtask

  initial begin
    bit done;
    done = 0;
    fork
      begin
        repeat (195000) @(posedge clk);
        if (!done) begin
          failures++;
          checks++;
          $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    for (int i = 0; i < 128; i++) expMem[i] = pat(i);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // reset state: R4 R9 R10
    chk(sdoOe == 1'b0, "R4 reset oe", sdoOe, 0);
    chk(wpOut == 1'b0 && oneHzEn == 1'b0 && alarmIrqEn == 2'b00, "R9 reset ctrl",
        {wpOut, oneHzEn, alarmIrqEn}, 0);
    chk(trickleDiodes == 2'b11 && trickleRes == 2'b00 && trickleOn == 1'b0, "R10 reset trickle",
        {trickleOn, trickleDiodes, trickleRes}, 5'b01100);

    // clock region burst read with wrap 1Fh->00h, idle-low four-wire: R2 R5 R6 R9 R10 R11
    readCheck(1, 0, 'h00, 34, "R5 R6 R9 R10 R11 clock read");
    // RAM region burst read with wrap 7Fh->20h, idle-high four-wire: R2 R5
    readCheck(1, 1, 'h20, 98, "R2 R5 ram read pol1");
    chk(addrOeCnt == 0 && dataOeBad == 0, "R4 oe framing", addrOeCnt + dataOeBad, 0);
    // reads leave memory untouched: R1
    chk(extMem[16] == expMem[16] && extMem[32] == expMem[32], "R1 read no write",
        extMem[32], expMem[32]);

    // three-wire RAM burst write with wrap FFh->A0h: R3 R5 R11
    begin
      int a;
      a = 'h20;
      for (int k = 0; k < 98; k++) begin
        txBuf[k] = 8'((k * 13 + 5) & 255);
        expMem[a] = txBuf[k];
        a = nextIdx(a);
      end
      xfer(0, 0, 8'hA0, 98, 8);
      for (int i = 'h20; i < 128; i++)
        chk(extMem[i] == expMem[i], "R3 R5 R11 ram write", extMem[i], expMem[i]);
      readCheck(0, 0, 'h20, 96, "R3 three-wire read");
    end

    // clock write wrap 9Fh->80h, reserved writes ignored: R5 R6
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33;
    xfer(1, 0, 8'h9E, 3, 8);
    expMem[0] = 8'h33;
    chk(extMem[0] == 8'h33, "R5 write wrap", extMem[0], 8'h33);
    chk(extMem['h1E] == pat('h1E) && extMem['h1F] == pat('h1F), "R6 reserved write",
        extMem['h1E], pat('h1E));
    readCheck(0, 0, 'h1E, 3, "R6 R5 reserved read");

    // control register and write protect: R8 R9
    txBuf[0] = 8'h07;
    xfer(1, 1, 8'h8F, 1, 8);
    ctlExp = 8'h07;
    chk(oneHzEn == 1'b1 && alarmIrqEn == 2'b11 && wpOut == 1'b0, "R9 ctrl write",
        {wpOut, oneHzEn, alarmIrqEn}, 4'b0111);
    txBuf[0] = 8'h45;
    xfer(1, 0, 8'h8F, 1, 8);
    ctlExp = 8'h45;
    chk(wpOut == 1'b1 && alarmIrqEn == 2'b01, "R8 wp set", {wpOut, alarmIrqEn}, 3'b101);
    txBuf[0] = 8'hAA;
    xfer(0, 0, 8'h80, 1, 8);
    chk(extMem[0] == 8'h33, "R8 protected ext write", extMem[0], 8'h33);
    txBuf[0] = 8'hA5;
    xfer(1, 0, 8'h91, 1, 8);
    chk(trickleOn == 1'b0 && trickleRes == 2'b00, "R8 protected trickle", trickleOn, 0);
    txBuf[0] = 8'h02;
    xfer(1, 0, 8'h8F, 1, 8);
    ctlExp = 8'h05;
    chk(wpOut == 1'b0 && oneHzEn == 1'b1 && alarmIrqEn == 2'b01, "R8 clear only wp",
        {wpOut, oneHzEn, alarmIrqEn}, 4'b0101);
    readCheck(0, 0, 'h0F, 1, "R9 ctrl readback");

    // partial byte abort then full write: R7 R1
    txBuf[0] = 8'hEE;
    xfer(1, 0, 8'h85, 1, 5);
    chk(extMem[5] == expMem[5], "R7 abort", extMem[5], expMem[5]);
    txBuf[0] = 8'h3C;
    xfer(0, 0, 8'h85, 1, 8);
    expMem[5] = 8'h3C;
    chk(extMem[5] == 8'h3C, "R1 R7 full write", extMem[5], 8'h3C);

    // charger decode sweep over every value: R10
    for (int v = 0; v < 256; v++) begin
      bit expOn;
      txBuf[0] = 8'(v);
      xfer(v[0], v[1], 8'h91, 1, 8);
      trkExp = 8'(v);
      expOn = (v[7:4] == 4'b1010) && (v[3:2] == 2'b01 || v[3:2] == 2'b10) && (v[1:0] != 2'b00);
      chk(trickleOn == expOn && trickleDiodes == v[3:2] && trickleRes == v[1:0], "R10 trickle",
          {trickleOn, trickleDiodes, trickleRes}, {expOn, v[3:0]});
    end
    readCheck(1, 1, 'h11, 1, "R10 trickle readback");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule